// File: doc/BRIEF.md
# Conversion Result Offset and Gain Pipeline

This block post-processes every raw conversion result on its way to storage. A raw sample arrives with a valid strobe and the number of the channel it was taken from. The block looks for an offset slot aimed at that channel and adds or subtracts the slot's offset. It can then scale the value by a programmable gain and clamp it to the output range. Last, it shifts the value left by a programmable amount. The result leaves with its own valid strobe and the same channel number.

Four offset slots are available. Each holds an offset magnitude, a target channel, a direction bit and two saturation enables. A slot holding a zero offset is switched off. When more than one active slot aims at the same channel, the lowest-numbered one is used. Its saturation enables govern the clamp stage for that sample. When no slot applies, the value wraps.

All configuration arrives as plain inputs. It must be held stable while samples are in flight, because each stage reads it in the cycle that stage works.

Top module: `result_post_proc`

## Requirements
- R1: A slot applies to a sample when its offset is non-zero and its channel field equals `in_chan`. With `slot_add` low, the applied offset is subtracted from the raw value, which is taken as unsigned.
- R2: With `slot_add` high for the applied slot, the offset is added to the raw value instead.
- R3: When several applicable slots target the same channel, only the slot with the lowest index is applied. Its offset, direction and saturation enables are used, and those of the other slots are not.
- R4: A slot whose offset is zero is ignored. A higher-index slot aimed at the same channel then applies. When no slot applies, no offset is applied and no saturation is enabled.
- R5: When `gain_en` is high, the value is multiplied by `gain_coef`/4096 and rounded toward minus infinity. When `gain_en` is low, the value passes unchanged.
- R6: Unsigned saturation (`slot_usat` of the applied slot high, `slot_ssat` low) clamps negative values to 0 and values above 2^16-1 to 2^16-1.
- R7: Signed saturation (`slot_ssat` of the applied slot high) clamps to the range -32768 to 32767. It takes precedence when both enables are set.
- R8: With neither saturation enabled, the 16 low bits of the value are kept and the rest are dropped.
- R9: The 16-bit clamped value is extended to 31 bits and shifted left by `lshift` (0 to 15). Signed saturation extends it with its sign bit; the other modes fill with zeros. Vacated low bits are zero.
- R10: Each sample appears exactly 4 cycles after it is presented, with the same channel number. A sample is accepted in every cycle. After reset, `out_valid` and `out_data` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Raw sample valid |
| in_chan | input | 5 | Channel number of the raw sample |
| in_raw | input | 16 | Raw unsigned conversion value |
| slot_val | input | 96 | Four 24-bit offset magnitudes, slot i in bits [24i+23:24i] |
| slot_chan | input | 20 | Four 5-bit target channels, slot i in bits [5i+4:5i] |
| slot_add | input | 4 | Per-slot direction, 1 adds the offset |
| slot_usat | input | 4 | Per-slot unsigned saturation enable |
| slot_ssat | input | 4 | Per-slot signed saturation enable |
| gain_en | input | 1 | Gain scaling enable |
| gain_coef | input | 14 | Gain coefficient, factor is value/4096 |
| lshift | input | 4 | Final left shift amount |
| out_valid | output | 1 | Result valid |
| out_chan | output | 5 | Channel number of the result |
| out_data | output | 31 | Processed result |

## Verification
Errors in slot selection show up in the first result from the affected channel. A wrong priority, or a zero slot that still takes part, gives a result that is off by a whole offset and may also fall in the wrong saturation mode. Wrong pipeline state shows up 4 cycles after the sample that entered it. A lost or doubled valid, a stale channel, or data from a neighbouring sample can be seen on the very next compare of a back-to-back stream. Rounding or sign errors in the gain and clamp stages show up in results near zero and near the clamp limits, which the directed vectors target.

// File: rtl/rpp_pkg.sv
// Shared types for the result post-processing pipeline.
package rpp_pkg;
    // Saturation selection carried along with each sample.
    typedef struct packed {
        logic usat;
        logic ssat;
    } satmode_t;
endpackage

// File: rtl/rpp_offset.sv
// Offset stage: picks the lowest-index active slot aimed at the incoming
// channel and adds or subtracts its offset. Assumes the raw value is unsigned.
module rpp_offset
    import rpp_pkg::*;
#(
    parameter int RAW_W = 16,
    parameter int OFS_W = 24,
    parameter int CH_W  = 5,
    parameter int NSLOT = 4,
    parameter int A_W   = 26
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [CH_W-1:0]         in_chan,
    input  logic [RAW_W-1:0]        in_raw,
    input  logic [NSLOT*OFS_W-1:0]  slot_val,
    input  logic [NSLOT*CH_W-1:0]   slot_chan,
    input  logic [NSLOT-1:0]        slot_add,
    input  logic [NSLOT-1:0]        slot_usat,
    input  logic [NSLOT-1:0]        slot_ssat,
    output logic                    o_valid,
    output logic [CH_W-1:0]         o_chan,
    output logic signed [A_W-1:0]   o_val,
    output satmode_t                o_mode
);
    logic [NSLOT-1:0]      hit;
    logic                  sel_hit;
    logic                  sel_add;
    logic [OFS_W-1:0]      sel_val;
    satmode_t              sel_mode;
    logic signed [A_W-1:0] raw_ext;
    logic signed [A_W-1:0] ofs_ext;
    logic signed [A_W-1:0] nxt_val;

    // Per-slot match: active offset and channel equality.
    for (genvar g = 0; g < NSLOT; g++) begin : g_hit
        assign hit[g] = (slot_val[g*OFS_W +: OFS_W] != '0) &&
                        (slot_chan[g*CH_W +: CH_W] == in_chan);
    end

    // Priority pick, lowest index last so it wins; then offset arithmetic.
    always_comb begin
        sel_hit  = 1'b0;
        sel_add  = 1'b0;
        sel_val  = '0;
        sel_mode = '0;
        for (int i = NSLOT - 1; i >= 0; i--) begin
            if (hit[i]) begin
                sel_hit       = 1'b1;
                sel_add       = slot_add[i];
                sel_val       = slot_val[i*OFS_W +: OFS_W];
                sel_mode.usat = slot_usat[i];
                sel_mode.ssat = slot_ssat[i];
            end
        end
        raw_ext = signed'({{(A_W-RAW_W){1'b0}}, in_raw});
        ofs_ext = signed'({{(A_W-OFS_W){1'b0}}, sel_val});
        if (!sel_hit)
            nxt_val = raw_ext;
        else if (sel_add)
            nxt_val = raw_ext + ofs_ext;
        else
            nxt_val = raw_ext - ofs_ext;
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_chan  <= '0;
            o_val   <= '0;
            o_mode  <= '0;
        end else begin
            o_valid <= in_valid;
            o_chan  <= in_chan;
            o_val   <= nxt_val;
            o_mode  <= sel_mode;
        end
    end
endmodule

// File: rtl/rpp_gain.sv
// Gain stage: multiplies by coef/2^FRAC with floor rounding when enabled,
// else sign-extends the value. Assumes the coefficient is unsigned.
module rpp_gain
    import rpp_pkg::*;
#(
    parameter int CH_W   = 5,
    parameter int A_W    = 26,
    parameter int G_W    = 28,
    parameter int GAIN_W = 14,
    parameter int FRAC   = 12
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_valid,
    input  logic [CH_W-1:0]       i_chan,
    input  logic signed [A_W-1:0] i_val,
    input  satmode_t              i_mode,
    input  logic                  gain_en,
    input  logic [GAIN_W-1:0]     gain_coef,
    output logic                  o_valid,
    output logic [CH_W-1:0]       o_chan,
    output logic signed [G_W-1:0] o_val,
    output satmode_t              o_mode
);
    localparam int P_W = A_W + GAIN_W + 1;

    logic signed [P_W-1:0] prod;
    logic signed [P_W-1:0] scaled;
    logic signed [G_W-1:0] nxt_val;

    // Signed product and arithmetic shift (floor) or bypass.
    always_comb begin
        prod    = P_W'(i_val) * signed'({{(P_W-GAIN_W){1'b0}}, gain_coef});
        scaled  = prod >>> FRAC;
        nxt_val = gain_en ? scaled[G_W-1:0] : {{(G_W-A_W){i_val[A_W-1]}}, i_val};
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_chan  <= '0;
            o_val   <= '0;
            o_mode  <= '0;
        end else begin
            o_valid <= i_valid;
            o_chan  <= i_chan;
            o_val   <= nxt_val;
            o_mode  <= i_mode;
        end
    end
endmodule

// File: rtl/rpp_sat.sv
// Clamp stage: signed clamp has precedence over unsigned clamp; with neither
// enabled the low SAT_W bits are kept. Flags whether the result is signed.
module rpp_sat
    import rpp_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int G_W   = 28,
    parameter int SAT_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  i_valid,
    input  logic [CH_W-1:0]       i_chan,
    input  logic signed [G_W-1:0] i_val,
    input  satmode_t              i_mode,
    output logic                  o_valid,
    output logic [CH_W-1:0]       o_chan,
    output logic [SAT_W-1:0]      o_val,
    output logic                  o_sx
);
    localparam logic signed [G_W-1:0] SMAX = {{(G_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [G_W-1:0] SMIN = {{(G_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};
    localparam logic signed [G_W-1:0] UMAX = {{(G_W-SAT_W){1'b0}}, {SAT_W{1'b1}}};

    logic [SAT_W-1:0] nxt_val;

    // Clamp selection by saturation mode.
    always_comb begin
        nxt_val = i_val[SAT_W-1:0];
        if (i_mode.ssat) begin
            if (i_val > SMAX)      nxt_val = SMAX[SAT_W-1:0];
            else if (i_val < SMIN) nxt_val = SMIN[SAT_W-1:0];
        end else if (i_mode.usat) begin
            if (i_val > UMAX)      nxt_val = UMAX[SAT_W-1:0];
            else if (i_val < 0)    nxt_val = '0;
        end
    end

    // Stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_chan  <= '0;
            o_val   <= '0;
            o_sx    <= 1'b0;
        end else begin
            o_valid <= i_valid;
            o_chan  <= i_chan;
            o_val   <= nxt_val;
            o_sx    <= i_mode.ssat;
        end
    end
endmodule

// File: rtl/result_post_proc.sv
// Result post-processing pipeline: offset, gain, clamp, left shift, one
// register per stage (latency 4). Assumes configuration is held stable while
// samples are in flight.
module result_post_proc
    import rpp_pkg::*;
#(
    parameter int RAW_W  = 16,
    parameter int OFS_W  = 24,
    parameter int CH_W   = 5,
    parameter int NSLOT  = 4,
    parameter int GAIN_W = 14,
    parameter int FRAC   = 12,
    parameter int SAT_W  = 16,
    parameter int SH_W   = 4,
    localparam int A_W   = ((RAW_W > OFS_W) ? RAW_W : OFS_W) + 2,
    localparam int G_W   = A_W + 2,
    localparam int RES_W = SAT_W + (1 << SH_W) - 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [CH_W-1:0]        in_chan,
    input  logic [RAW_W-1:0]       in_raw,
    input  logic [NSLOT*OFS_W-1:0] slot_val,
    input  logic [NSLOT*CH_W-1:0]  slot_chan,
    input  logic [NSLOT-1:0]       slot_add,
    input  logic [NSLOT-1:0]       slot_usat,
    input  logic [NSLOT-1:0]       slot_ssat,
    input  logic                   gain_en,
    input  logic [GAIN_W-1:0]      gain_coef,
    input  logic [SH_W-1:0]        lshift,
    output logic                   out_valid,
    output logic [CH_W-1:0]        out_chan,
    output logic [RES_W-1:0]       out_data
);
    logic                  s1_valid, s2_valid, s3_valid;
    logic [CH_W-1:0]       s1_chan, s2_chan, s3_chan;
    logic signed [A_W-1:0] s1_val;
    logic signed [G_W-1:0] s2_val;
    logic [SAT_W-1:0]      s3_val;
    satmode_t              s1_mode, s2_mode;
    logic                  s3_sx;
    logic [RES_W-1:0]      s3_ext;

    rpp_offset #(.RAW_W(RAW_W), .OFS_W(OFS_W), .CH_W(CH_W), .NSLOT(NSLOT), .A_W(A_W)) u_ofs (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
        .slot_val(slot_val), .slot_chan(slot_chan), .slot_add(slot_add),
        .slot_usat(slot_usat), .slot_ssat(slot_ssat),
        .o_valid(s1_valid), .o_chan(s1_chan), .o_val(s1_val), .o_mode(s1_mode)
    );

    rpp_gain #(.CH_W(CH_W), .A_W(A_W), .G_W(G_W), .GAIN_W(GAIN_W), .FRAC(FRAC)) u_gain (
        .clk(clk), .rst_n(rst_n),
        .i_valid(s1_valid), .i_chan(s1_chan), .i_val(s1_val), .i_mode(s1_mode),
        .gain_en(gain_en), .gain_coef(gain_coef),
        .o_valid(s2_valid), .o_chan(s2_chan), .o_val(s2_val), .o_mode(s2_mode)
    );

    rpp_sat #(.CH_W(CH_W), .G_W(G_W), .SAT_W(SAT_W)) u_sat (
        .clk(clk), .rst_n(rst_n),
        .i_valid(s2_valid), .i_chan(s2_chan), .i_val(s2_val), .i_mode(s2_mode),
        .o_valid(s3_valid), .o_chan(s3_chan), .o_val(s3_val), .o_sx(s3_sx)
    );

    // Widen the clamped value, sign-filled only for signed saturation.
    always_comb begin
        s3_ext = s3_sx ? {{(RES_W-SAT_W){s3_val[SAT_W-1]}}, s3_val}
                       : {{(RES_W-SAT_W){1'b0}}, s3_val};
    end

    // Shift stage register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_chan  <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= s3_valid;
            out_chan  <= s3_chan;
            out_data  <= s3_ext << lshift;
        end
    end
endmodule

// File: rtl/rpp_checker.sv
// Property checker for result_post_proc, bound to it below. Observes ports
// and the hand-off signals between the stage modules.
module rpp_checker
    import rpp_pkg::*;
#(
    parameter int CH_W  = 5,
    parameter int A_W   = 26,
    parameter int G_W   = 28,
    parameter int SAT_W = 16,
    parameter int SH_W  = 4,
    parameter int RES_W = 31
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [CH_W-1:0]       in_chan,
    input logic                  gain_en,
    input logic [SH_W-1:0]       lshift,
    input logic signed [A_W-1:0] s1_val,
    input logic                  s2_valid,
    input logic signed [G_W-1:0] s2_val,
    input satmode_t              s2_mode,
    input logic                  s3_valid,
    input logic [SAT_W-1:0]      s3_val,
    input logic                  out_valid,
    input logic [CH_W-1:0]       out_chan,
    input logic [RES_W-1:0]      out_data
);
    localparam logic signed [G_W-1:0] SMAX = {{(G_W-SAT_W+1){1'b0}}, {(SAT_W-1){1'b1}}};
    localparam logic signed [G_W-1:0] SMIN = {{(G_W-SAT_W+1){1'b1}}, {(SAT_W-1){1'b0}}};

    logic [2:0] since;

    // Count cycles since reset, saturating at the pipeline depth.
    always_ff @(posedge clk) begin
        if (!rst_n)            since <= '0;
        else if (since != 3'd4) since <= since + 3'd1;
    end

    p_latency_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 3'd4) |-> (out_valid == $past(in_valid, 4)));

    p_chan_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (since == 3'd4 && out_valid) |-> (out_chan == $past(in_chan, 4)));

    p_gain_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && s2_valid && !$past(gain_en))
        |-> (s2_val == {{(G_W-A_W){$past(s1_val[A_W-1])}}, $past(s1_val)}));

    p_ssat_pass_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && s3_valid && $past(s2_mode.ssat) &&
         $past(s2_val) <= SMAX && $past(s2_val) >= SMIN)
        |-> (s3_val == $past(s2_val[SAT_W-1:0])));

    p_usat_floor_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && s3_valid && $past(s2_mode.usat) && !$past(s2_mode.ssat) &&
         $past(s2_val) < 0)
        |-> (s3_val == '0));

    p_shift_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (since != 3'd0 && out_valid)
        |-> ((out_data & ~({RES_W{1'b1}} << $past(lshift))) == '0));
endmodule

bind result_post_proc rpp_checker #(
    .CH_W(CH_W), .A_W(A_W), .G_W(G_W), .SAT_W(SAT_W), .SH_W(SH_W), .RES_W(RES_W)
) u_rpp_checker (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan),
    .gain_en(gain_en), .lshift(lshift),
    .s1_val(s1_val), .s2_valid(s2_valid), .s2_val(s2_val), .s2_mode(s2_mode),
    .s3_valid(s3_valid), .s3_val(s3_val),
    .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
);

// File: tb/tb_result_post_proc.sv
// Bench: behavioural reference model with a 4-deep expectation queue,
// compared against the outputs at every falling edge.
module tb_result_post_proc;
    localparam int NS = 4;
    localparam int RES_W = 31;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            in_valid;
    logic [4:0]      in_chan;
    logic [15:0]     in_raw;
    logic [NS*24-1:0] f_val;
    logic [NS*5-1:0]  f_chan;
    logic [NS-1:0]   f_add, f_usat, f_ssat;
    logic            gain_en;
    logic [13:0]     gcoef;
    logic [3:0]      lsh;
    logic            out_valid;
    logic [4:0]      out_chan;
    logic [RES_W-1:0] out_data;

    logic [23:0] cv [NS];
    logic [4:0]  cc [NS];
    logic        ca [NS];
    logic        cu [NS];
    logic        cs [NS];

    for (genvar g = 0; g < NS; g++) begin : g_cfg
        assign f_val[g*24 +: 24] = cv[g];
        assign f_chan[g*5 +: 5]  = cc[g];
        assign f_add[g]          = ca[g];
        assign f_usat[g]         = cu[g];
        assign f_ssat[g]         = cs[g];
    end

    result_post_proc dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_chan(in_chan), .in_raw(in_raw),
        .slot_val(f_val), .slot_chan(f_chan), .slot_add(f_add),
        .slot_usat(f_usat), .slot_ssat(f_ssat),
        .gain_en(gain_en), .gain_coef(gcoef), .lshift(lsh),
        .out_valid(out_valid), .out_chan(out_chan), .out_data(out_data)
    );

    int    nvec = 0;
    int    nbad = 0;
    bit    done = 0;
    bit    qv[$];
    longint qd[$];
    int    qc[$];
    string qt[$];

    // Reference: offset, gain, clamp, shift, in plain integer arithmetic.
    function automatic longint model(int raw, int ch);
        longint v = raw;
        bit hit = 0, us = 0, ss = 0;
        for (int i = 0; i < NS; i++) begin
            if (!hit && cv[i] != 0 && int'(cc[i]) == ch) begin
                hit = 1;
                v = ca[i] ? v + longint'(cv[i]) : v - longint'(cv[i]);
                us = cu[i];
                ss = cs[i];
            end
        end
        if (gain_en) v = (v * longint'(gcoef)) >>> 12;
        if (ss) begin
            if (v > 32767) v = 32767;
            else if (v < -32768) v = -32768;
        end else if (us) begin
            if (v > 65535) v = 65535;
            else if (v < 0) v = 0;
        end else begin
            v = v & 64'hFFFF;
        end
        v = (v <<< lsh) & ((64'sd1 <<< RES_W) - 1);
        return v;
    endfunction

    // One cycle: compare the oldest expectation, then drive and enqueue.
    task automatic step(bit v, int raw, int ch, string tag);
        @(negedge clk);
        if (qv.size() == 4) begin
            bit ev = qv.pop_front();
            longint ed = qd.pop_front();
            int ec = qc.pop_front();
            string et = qt.pop_front();
            nvec++;
            if (out_valid !== ev) begin
                nbad++;
                $display("FAIL %s out_valid actual %0b expected %0b", et, out_valid, ev);
            end else if (ev && (longint'(out_data) != ed || int'(out_chan) != ec)) begin
                nbad++;
                $display("FAIL %s data/chan actual %0d/%0d expected %0d/%0d",
                         et, out_data, out_chan, ed, ec);
            end
        end
        in_valid = v;
        in_raw   = 16'(raw);
        in_chan  = 5'(ch);
        qv.push_back(v);
        qd.push_back(model(raw, ch));
        qc.push_back(ch);
        qt.push_back(tag);
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(0, 0, 0, "R10");
    endtask

    task automatic slot(int i, int val, int ch, bit add, bit us, bit ss);
        cv[i] = 24'(val); cc[i] = 5'(ch); ca[i] = add; cu[i] = us; cs[i] = ss;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            nbad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; in_valid = 0; in_raw = 0; in_chan = 0;
        gain_en = 0; gcoef = 0; lsh = 0;
        for (int i = 0; i < NS; i++) slot(i, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        nvec++;
        if (out_valid !== 1'b0 || out_data !== '0) begin
            nbad++;
            $display("FAIL R10 reset state actual %0b/%0d expected 0/0", out_valid, out_data);
        end
        @(negedge clk);
        rst_n = 1;
        idle(4);

        // R1 subtract, R6 unsigned floor, R8 unmatched channel wraps/passes
        slot(0, 100, 3, 0, 1, 0);
        step(1, 1000, 3, "R1");
        step(1, 50, 3, "R6");
        step(1, 65535, 7, "R8");
        idle(4);

        // R2 add with R7 signed clamp
        slot(1, 10, 5, 1, 0, 1);
        step(1, 32760, 5, "R7");
        step(1, 5, 5, "R2");
        idle(4);

        // R3 priority: slot 2 also targets channel 3, slot 0 must win
        slot(2, 500, 3, 1, 0, 0);
        step(1, 1000, 3, "R3");
        step(1, 20, 3, "R3");
        idle(4);

        // R4 zero slot disabled: slot 2 takes over
        slot(0, 0, 3, 0, 1, 0);
        step(1, 1000, 3, "R4");
        step(1, 65535, 3, "R4");
        idle(4);

        // R8 wrap of a negative result
        slot(3, 20, 9, 0, 0, 0);
        step(1, 10, 9, "R8");
        idle(4);

        // R5 gain
        gain_en = 1; gcoef = 14'd6144;
        step(1, 100, 5, "R5");
        idle(4);
        gcoef = 14'd16383;
        step(1, 10, 9, "R5");
        step(1, 1234, 9, "R5");
        idle(4);
        gcoef = 14'd0;
        step(1, 4000, 5, "R5");
        idle(4);
        gain_en = 0;

        // R6 upper clamp, R7 precedence when both enabled
        slot(1, 70000, 5, 1, 1, 0);
        step(1, 100, 5, "R6");
        idle(4);
        slot(1, 70000, 5, 1, 1, 1);
        step(1, 100, 5, "R7");
        idle(4);

        // R9 shift with sign fill, and with zero fill
        slot(1, 40000, 5, 0, 0, 1);
        lsh = 4'd15;
        step(1, 0, 5, "R9");
        idle(4);
        slot(0, 100, 3, 0, 1, 0);
        lsh = 4'd4;
        step(1, 1000, 3, "R9");
        step(1, 7, 9, "R9");
        idle(4);

        // R10 back-to-back stream under random configurations
        for (int k = 0; k < 40; k++) begin
            for (int i = 0; i < NS; i++)
                slot(i, ($urandom % 4 == 0) ? 0 : int'($urandom % 80000), $urandom % 4,
                     $urandom % 2, $urandom % 2, $urandom % 2);
            gain_en = $urandom % 2;
            gcoef   = 14'($urandom);
            lsh     = 4'($urandom);
            for (int j = 0; j < 8; j++)
                step($urandom % 4 != 0, int'($urandom % 65536), $urandom % 4, "R10");
            idle(4);
        end

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end
endmodule